// File: doc/BRIEF.md
# Spread-Spectrum Divider Profile Generator

This block drives the feedback-divider word of a fractional-N PLL so that the synthesized clock sweeps up and down in a triangle around a nominal frequency. The sweep spreads the clock's energy over a band and lowers its peak emission. The word is an unsigned fixed-point number with 16 fractional bits: a nominal multiplier M plus an offset. The block recomputes the offset on every reference tick. Two profiles are available. Center spread swings equally above and below M, so the mean frequency is nominal. Down spread has its peak exactly at M, so the mean frequency sits below nominal.

Four configuration sets sit in a small register bank, which is written through a one-cycle write port. Each set holds the multiplier M, the reference pre-divider N, the spread mode, the deviation code (in units of 0.125 %) and the sweep rate (slow or fast). A 2-bit select picks the set the block should follow. The set in use, called the live set, is replaced only at the minimum-frequency point of the triangle, so the PLL never sees a jump in the middle of a sweep. An active-low power-down input stops the sweep and raises a disable flag that lets the clock output be tri-stated.

The controller is a three-state machine:
- OFF is the reset and power-down state. The live set follows the selected bank entry every cycle.
- UP is the rising half of the triangle.
- DOWN is the falling half.

It has five transitions:
- OFF→UP when the power-down input is high.
- UP→DOWN on the tick that completes H rising steps.
- DOWN→UP on the tick that completes H falling steps. This tick also loads the live set.
- UP→OFF and DOWN→OFF whenever the power-down input is sampled low.

Top module: `ss_profile_gen`

## Requirements
- R1: After reset the block is in OFF with `out_disable`=1. All four bank entries hold M=1, N=1, center mode, deviation code 1 and slow rate, and `div_word` shows the minimum-point value of that default set.
- R2: Center spread (mode bit 0) uses step s = floor(M·2c·65536/(800·H)), with c the deviation code. The minimum is M·65536 − H·s/2, the midpoint after H/2 rising ticks is exactly M·65536, and the maximum is M·65536 + H·s/2.
- R3: Down spread (mode bit 1) uses step s = floor(M·c·65536/(800·H)). The peak equals M·65536 exactly, the minimum is M·65536 − H·s, and `div_word` never exceeds M·65536.
- R4: Deviation codes are clamped when written. Center mode limits them to 1..16 (0 becomes 1, anything above 16 becomes 16). Down mode limits them to 2..32 (0 and 1 become 2, anything above 32 becomes 32).
- R5: The profile is a triangle. Each tick adds s while rising and subtracts s while falling. Each half lasts H ticks, so a full period is 2H ticks. H is HALF_SLOW (default 32) for rate bit 0 and HALF_FAST (default 8) for rate bit 1.
- R6: A change of select or of bank contents takes effect only on the tick that ends a falling half. That tick loads the set selected at that moment and puts `div_word` at the new set's minimum.
- R7: Power-down sampled low moves the block to OFF by the next cycle. `out_disable` goes to 1 and `div_word` becomes the minimum-point value of the selected set. Ticks then have no effect. Releasing power-down restarts the sweep from the minimum, and the first tick rises by s.
- R8: `prediv` equals the N of the live set.
- R9: `div_word` changes in the cycle after a sampled tick and holds its value in every cycle with no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_n | input | 1 | Active-low power-down |
| tick | input | 1 | One-cycle reference tick that advances the sweep |
| sel | input | 2 | Selects the bank entry to follow |
| wr_en | input | 1 | Writes one bank entry |
| wr_addr | input | 2 | Bank entry to write |
| wr_mult | input | 12 | Multiplier M (1..2048) |
| wr_prediv | input | 11 | Pre-divider N (1..1024) |
| wr_down | input | 1 | Spread mode: 0 center, 1 down |
| wr_dev | input | 6 | Deviation code in 0.125 % units |
| wr_fast | input | 1 | Rate: 0 slow, 1 fast |
| div_word | output | 28 | Divider word, 12 integer bits and 16 fractional bits |
| prediv | output | 11 | Pre-divider of the live set |
| out_disable | output | 1 | High while in OFF, used to tri-state the clock |

## Verification
Every result is due one clock after the edge that samples its cause:
- A tick pulse driven at a falling edge moves `div_word` by the following falling edge.
- Power-down sampled low gives `out_disable`=1 and the new minimum one cycle later.
- Release of power-down gives the restarted minimum one cycle later.

The bench drives inputs at falling edges and samples outputs at the next falling edge. It counts ticks from a known minimum point, so every expected word (midpoint, peak, reversal, deferred set switch) falls on a known tick count.

// File: rtl/ss_pkg.sv
package ss_pkg;
    localparam int MULT_W  = 12;
    localparam int PDIV_W  = 11;
    localparam int DEV_W   = 6;
    localparam int FRAC_W  = 16;
    localparam int CTR_DEV_MIN = 1;
    localparam int CTR_DEV_MAX = 16;
    localparam int DN_DEV_MIN  = 2;
    localparam int DN_DEV_MAX  = 32;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [PDIV_W-1:0] prediv;
        logic              down;
        logic [DEV_W-1:0]  dev;
        logic              fast;
    } ss_cfg_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } sweep_state_e;

    localparam ss_cfg_t CFG_RESET = '{mult: MULT_W'(1), prediv: PDIV_W'(1),
                                      down: 1'b0, dev: DEV_W'(1), fast: 1'b0};
endpackage

// File: rtl/ss_cfg_bank.sv
module ss_cfg_bank
    import ss_pkg::*;
#(
    parameter int NSETS = 4,
    localparam int SEL_W = $clog2(NSETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  ss_cfg_t          wr_cfg,
    input  logic [SEL_W-1:0] sel,
    output ss_cfg_t          rd_cfg
);
    ss_cfg_t ent_q [NSETS];
    ss_cfg_t wr_clamped;

    always_comb begin
        wr_clamped = wr_cfg;
        if (wr_cfg.down) begin
            if (int'(wr_cfg.dev) < DN_DEV_MIN)      wr_clamped.dev = DEV_W'(DN_DEV_MIN);
            else if (int'(wr_cfg.dev) > DN_DEV_MAX) wr_clamped.dev = DEV_W'(DN_DEV_MAX);
        end else begin
            if (int'(wr_cfg.dev) < CTR_DEV_MIN)      wr_clamped.dev = DEV_W'(CTR_DEV_MIN);
            else if (int'(wr_cfg.dev) > CTR_DEV_MAX) wr_clamped.dev = DEV_W'(CTR_DEV_MAX);
        end
    end

    for (genvar g = 0; g < NSETS; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q[g] <= CFG_RESET;
            else if (wr_en && wr_addr == SEL_W'(g))
                ent_q[g] <= wr_clamped;
        end
    end

    assign rd_cfg = ent_q[sel];

    AST_DEV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cfg.down ? (int'(rd_cfg.dev) >= DN_DEV_MIN && int'(rd_cfg.dev) <= DN_DEV_MAX)
                    : (int'(rd_cfg.dev) >= CTR_DEV_MIN && int'(rd_cfg.dev) <= CTR_DEV_MAX)); // R4
endmodule

// File: rtl/ss_step_calc.sv
module ss_step_calc
    import ss_pkg::*;
#(
    parameter int HALF_SLOW = 32,
    parameter int HALF_FAST = 8,
    localparam int HMAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST,
    localparam int CNT_W = $clog2(HMAX) + 1,
    localparam int ACC_W = MULT_W + DEV_W + 1 + FRAC_W
) (
    input  ss_cfg_t          cfg,
    output logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] span,
    output logic [CNT_W-1:0] hlen
);
    logic [DEV_W:0]   pp_code;
    logic [ACC_W-1:0] num;
    logic [ACC_W-1:0] den;

    always_comb begin
        // Peak-to-peak swing in 0.125 % units: twice the code for center.
        pp_code = cfg.down ? {1'b0, cfg.dev} : {cfg.dev, 1'b0};
        hlen    = cfg.fast ? CNT_W'(HALF_FAST) : CNT_W'(HALF_SLOW);
        num     = (ACC_W'(cfg.mult) * ACC_W'(pp_code)) << FRAC_W;
        den     = cfg.fast ? ACC_W'(800 * HALF_FAST) : ACC_W'(800 * HALF_SLOW);
        step    = num / den;
        span    = step * ACC_W'(hlen);
    end
endmodule

// File: rtl/ss_sweep_fsm.sv
module ss_sweep_fsm
    import ss_pkg::*;
#(
    parameter int HALF_SLOW = 32,
    parameter int HALF_FAST = 8,
    localparam int HMAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST,
    localparam int CNT_W = $clog2(HMAX) + 1,
    localparam int ACC_W = MULT_W + DEV_W + 1 + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             tick,
    input  ss_cfg_t          bank_cfg,
    input  logic [ACC_W-1:0] step,
    input  logic [ACC_W-1:0] span,
    input  logic [CNT_W-1:0] hlen,
    output sweep_state_e     state_q,
    output logic [ACC_W-1:0] acc_q,
    output ss_cfg_t          live_q
);
    sweep_state_e     state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == hlen - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = pd_n ? ST_UP : ST_OFF;
            ST_UP:   if (!pd_n) state_d = ST_OFF;
                     else if (tick && last) state_d = ST_DOWN;
            ST_DOWN: if (!pd_n) state_d = ST_OFF;
                     else if (tick && last) state_d = ST_UP;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            live_q <= CFG_RESET;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    cnt_q  <= '0;
                    acc_q  <= '0;
                    live_q <= bank_cfg;
                end
                ST_UP: begin
                    if (!pd_n) begin
                        cnt_q  <= '0;
                        acc_q  <= '0;
                        live_q <= bank_cfg;
                    end else if (tick) begin
                        acc_q <= acc_q + step;
                        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
                    end
                end
                ST_DOWN: begin
                    if (!pd_n) begin
                        cnt_q  <= '0;
                        acc_q  <= '0;
                        live_q <= bank_cfg;
                    end else if (tick) begin
                        if (last) begin
                            cnt_q  <= '0;
                            acc_q  <= '0;
                            live_q <= bank_cfg;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                            acc_q <= acc_q - step;
                        end
                    end
                end
                default: begin
                    cnt_q <= '0;
                    acc_q <= '0;
                end
            endcase
        end
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= span); // R5
    AST_PD_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> state_q == ST_OFF); // R7
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !tick && state_q != ST_OFF) |=> $stable(acc_q)); // R9
    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && state_q != ST_OFF && !(tick && state_q == ST_DOWN && last))
        |=> $stable(live_q)); // R6
endmodule

// File: rtl/ss_profile_gen.sv
module ss_profile_gen
    import ss_pkg::*;
#(
    parameter int HALF_SLOW = 32,
    parameter int HALF_FAST = 8,
    localparam int HMAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST,
    localparam int CNT_W = $clog2(HMAX) + 1,
    localparam int ACC_W = MULT_W + DEV_W + 1 + FRAC_W,
    localparam int OUT_W = MULT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              tick,
    input  logic [1:0]        sel,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [MULT_W-1:0] wr_mult,
    input  logic [PDIV_W-1:0] wr_prediv,
    input  logic              wr_down,
    input  logic [DEV_W-1:0]  wr_dev,
    input  logic              wr_fast,
    output logic [OUT_W-1:0]  div_word,
    output logic [PDIV_W-1:0] prediv,
    output logic              out_disable
);
    ss_cfg_t          wr_cfg;
    ss_cfg_t          bank_cfg;
    ss_cfg_t          live_cfg;
    sweep_state_e     state;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] span;
    logic [CNT_W-1:0] hlen;
    logic [OUT_W-1:0] nominal;
    logic [OUT_W-1:0] low_ofs;

    assign wr_cfg = '{mult: wr_mult, prediv: wr_prediv, down: wr_down,
                      dev: wr_dev, fast: wr_fast};

    ss_cfg_bank #(.NSETS(4)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_cfg  (wr_cfg),
        .sel     (sel),
        .rd_cfg  (bank_cfg)
    );

    ss_step_calc #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_calc (
        .cfg  (live_cfg),
        .step (step),
        .span (span),
        .hlen (hlen)
    );

    ss_sweep_fsm #(.HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_n     (pd_n),
        .tick     (tick),
        .bank_cfg (bank_cfg),
        .step     (step),
        .span     (span),
        .hlen     (hlen),
        .state_q  (state),
        .acc_q    (acc),
        .live_q   (live_cfg)
    );

    always_comb begin
        nominal     = {live_cfg.mult, {FRAC_W{1'b0}}};
        // Distance from nominal down to the triangle's minimum point.
        low_ofs     = live_cfg.down ? OUT_W'(span) : OUT_W'(span >> 1);
        div_word    = nominal + OUT_W'(acc) - low_ofs;
        prediv      = live_cfg.prediv;
        out_disable = (state == ST_OFF);
    end

    AST_DOWN_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        live_cfg.down |-> div_word <= nominal); // R3
    AST_OFF_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_disable |-> div_word == nominal - low_ofs); // R7
endmodule

// File: tb/tb_ss_profile_gen.sv
module tb_ss_profile_gen;
    import ss_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HS = 32;
    localparam int HF = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pd_n = 1'b0;
    logic              tick = 1'b0;
    logic [1:0]        sel = 2'd0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = 2'd0;
    logic [MULT_W-1:0] wr_mult = '0;
    logic [PDIV_W-1:0] wr_prediv = '0;
    logic              wr_down = 1'b0;
    logic [DEV_W-1:0]  wr_dev = '0;
    logic              wr_fast = 1'b0;
    logic [27:0]       div_word;
    logic [PDIV_W-1:0] prediv;
    logic              out_disable;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ss_profile_gen #(.HALF_SLOW(HS), .HALF_FAST(HF)) dut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .tick(tick), .sel(sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_mult(wr_mult),
        .wr_prediv(wr_prediv), .wr_down(wr_down), .wr_dev(wr_dev),
        .wr_fast(wr_fast), .div_word(div_word), .prediv(prediv),
        .out_disable(out_disable)
    );

    function automatic longint clampc(bit down, int c);
        if (down) return (c < 2) ? 2 : ((c > 32) ? 32 : c);
        return (c < 1) ? 1 : ((c > 16) ? 16 : c);
    endfunction

    function automatic longint hlen_of(bit fast);
        return fast ? HF : HS;
    endfunction

    function automatic longint step_of(longint m, bit down, int c, bit fast);
        longint cc = clampc(down, c);
        longint pp = down ? cc : 2 * cc;
        return (m * pp * 65536) / (800 * hlen_of(fast));
    endfunction

    function automatic longint min_of(longint m, bit down, int c, bit fast);
        longint span = hlen_of(fast) * step_of(m, down, c, fast);
        return m * 65536 - (down ? span : span / 2);
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_div(string tag, longint exp);
        check(longint'(div_word) == exp, tag, longint'(div_word), exp);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic write_set(int a, int m, int n, bit down, int c, bit fast);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_mult = MULT_W'(m);
        wr_prediv = PDIV_W'(n); wr_down = down; wr_dev = DEV_W'(c); wr_fast = fast;
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic restart(int s);
        @(negedge clk) pd_n = 1'b0;
        @(negedge clk) sel = 2'(s);
        @(negedge clk) pd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(out_disable == 1'b1, "R1 disable after reset", longint'(out_disable), 1);
        chk_div("R1 default minimum", min_of(1, 0, 1, 0));
        check(prediv == 1, "R1 default prediv", longint'(prediv), 1);
    endtask

    task automatic t_center();
        longint mn = min_of(100, 0, 8, 0);
        longint s  = step_of(100, 0, 8, 0);
        restart(0);
        check(out_disable == 1'b0, "R7 enabled after release", longint'(out_disable), 0);
        chk_div("R2 center minimum", mn);
        check(prediv == 4, "R8 prediv of set0", longint'(prediv), 4);
        ticks(1);
        chk_div("R5 first rising step", mn + s);
        repeat (5) @(negedge clk);
        chk_div("R9 hold without tick", mn + s);
        ticks(15);
        chk_div("R2 center midpoint equals nominal", 100 * 65536);
        ticks(16);
        chk_div("R2 center maximum", 101 * 65536);
        ticks(1);
        chk_div("R5 reversal at peak", 101 * 65536 - s);
        ticks(31);
        chk_div("R5 back to minimum after 2H", mn);
    endtask

    task automatic t_down();
        longint mn = min_of(200, 1, 16, 1);
        longint s  = step_of(200, 1, 16, 1);
        restart(1);
        chk_div("R3 down minimum", mn);
        ticks(8);
        chk_div("R3 down peak equals nominal", 200 * 65536);
        ticks(1);
        chk_div("R5 fast reversal", 200 * 65536 - s);
        ticks(7);
        chk_div("R5 fast period 2H", mn);
    endtask

    task automatic t_clamp();
        restart(2);
        chk_div("R4 down code 40 clamped to 32", min_of(50, 1, 32, 0));
        chk_div("R4 down code 40 clamped, 4pct", 48 * 65536);
        ticks(32);
        chk_div("R4 clamped down peak", 50 * 65536);
        restart(3);
        chk_div("R4 center code 0 clamped to 1", 799 * 65536);
    endtask

    task automatic t_switch();
        longint mn0 = min_of(100, 0, 8, 0);
        longint s0  = step_of(100, 0, 8, 0);
        restart(0);
        ticks(10);
        @(negedge clk) sel = 2'd1;
        ticks(1);
        chk_div("R6 old set kept after select change", mn0 + 11 * s0);
        check(prediv == 4, "R6 prediv unchanged mid sweep", longint'(prediv), 4);
        ticks(52);
        chk_div("R6 old set until minimum", mn0 + s0);
        ticks(1);
        chk_div("R6 new set at minimum", min_of(200, 1, 16, 1));
        check(prediv == 9, "R8 prediv of new live set", longint'(prediv), 9);
        ticks(1);
        chk_div("R5 new set step", min_of(200, 1, 16, 1) + step_of(200, 1, 16, 1));
    endtask

    task automatic t_pd();
        longint mn2 = min_of(50, 1, 32, 0);
        restart(0);
        ticks(5);
        @(negedge clk); pd_n = 1'b0; sel = 2'd2;
        @(negedge clk);
        check(out_disable == 1'b1, "R7 disable on power-down", longint'(out_disable), 1);
        chk_div("R7 selected minimum in power-down", mn2);
        ticks(3);
        chk_div("R7 ticks ignored in power-down", mn2);
        @(negedge clk) pd_n = 1'b1;
        @(negedge clk);
        check(out_disable == 1'b0, "R7 enable after release", longint'(out_disable), 0);
        chk_div("R7 restart at minimum", mn2);
        ticks(1);
        chk_div("R7 first step after restart", mn2 + step_of(50, 1, 32, 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        write_set(0, 100, 4, 0, 8, 0);
        write_set(1, 200, 9, 1, 16, 1);
        write_set(2, 50, 3, 1, 40, 0);
        write_set(3, 800, 7, 0, 0, 1);
        t_center();
        t_down();
        t_clamp();
        t_switch();
        t_pd();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule